// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block turns one auxiliary-channel request into the byte sequence that goes out on the link, and turns the bytes that come back into a short verdict. On the request side it takes a 4-bit command, a 20-bit address, a transfer length and a write flag. It emits a three- or four-byte header. For write commands it then passes the payload bytes through from an input stream. On the reply side it takes the reply byte count and the receiver's error flags at the start of a reply. It then reads the reply bytes from a receive stream, forwards the data bytes of an acknowledged reply, and reports a result code, the reply code and the number of data bytes.

The transmit, payload, receive and data interfaces are valid/ready streams. A byte moves on a rising edge where both valid and ready are high. A source that has raised valid keeps the byte and valid unchanged until the byte is taken. The framer holds `tx_data` steady while `tx_ready` is low. While the payload is being sent, `tx_valid` follows `pay_valid` and `pay_ready` follows `tx_ready`, so back-pressure from the link reaches the payload source with no storage in between. The start handshakes (`req_valid`/`req_ready`, `rep_start`/`rep_ready`) follow the same rule. The result is a one-cycle pulse and has no back-pressure.

Top module: `aux_xact_codec`

## Requirements
- R1: The first transmitted byte carries the command in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: The second and third transmitted bytes are address bits 15:8 and address bits 7:0.
- R3: A fourth header byte equal to length minus one is sent only when the length is nonzero. A zero-length request sends a three-byte header.
- R4: Payload bytes follow the header only when `req_write` is 1. They are taken from the payload stream in arrival order, and a read request leaves that stream untouched. `tx_count` equals the header size plus, for a write, the length. `tx_last` marks the final byte.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged on the next cycle.
- R6: `rep_flags` bit 5 (hot-plug lost) has the highest priority. It gives result 3 in the cycle after the reply is accepted, and no receive byte is consumed. Result encoding: 0 success, 1 timeout, 2 invalid reply, 3 hot-plug lost, 4 overflow.
- R7: If bit 5 is clear, `rep_flags` bit 0 (timeout) gives result 1 in the cycle after acceptance, whatever the other flags are, and no receive byte is consumed.
- R8: If bits 5 and 0 are clear, any of bit 1 (bad stop), bit 2 (no detect), bit 3 (bad high symbol) or bit 4 (bad low symbol) gives result 2, and no receive byte is consumed.
- R9: With no flags set, a reply byte count of zero gives result 2.
- R10: Otherwise all `rep_count` bytes are consumed. `res_reply` is bits 7:4 of the first byte, and the result is 0 with `res_dcount` equal to `rep_count` minus one. The remaining bytes are forwarded on the data stream only when the reply code is 0 (acknowledge); otherwise they are discarded. Any nonzero result reports `res_dcount` 0, and no data is forwarded while the parser is idle.
- R11: An acknowledged reply whose data count exceeds `rep_limit` gives result 4. Its bytes are drained and none is forwarded. A data count equal to the limit is a success.
- R12: `res_valid` is a single-cycle pulse. `req_ready` is low from the cycle after a request is accepted until its last byte has gone out, and `rep_ready` is low while a reply is being handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Framer idle, request taken on this edge |
| req_cmd | input | 4 | Command nibble |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Transfer length in bytes (0..MAX_LEN) |
| req_write | input | 1 | 1 when the command carries payload |
| pay_valid | input | 1 | Payload byte offered |
| pay_ready | output | 1 | Payload byte taken |
| pay_data | input | 8 | Payload byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Link takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the request |
| tx_count | output | CNT_W | Total bytes of the current request |
| rep_start | input | 1 | Reply available to parse |
| rep_ready | output | 1 | Parser idle, reply taken on this edge |
| rep_count | input | CNT_W | Number of reply bytes received |
| rep_limit | input | CNT_W | Largest data count the requester accepts |
| rep_flags | input | 6 | Receiver flags, bit positions as in R6 to R8 |
| rx_valid | input | 1 | Reply byte offered |
| rx_ready | output | 1 | Reply byte taken |
| rx_data | input | 8 | Reply byte |
| dat_valid | output | 1 | Data byte offered |
| dat_ready | input | 1 | Data byte taken |
| dat_data | output | 8 | Data byte of an acknowledged reply |
| res_valid | output | 1 | Result pulse |
| res_code | output | 3 | Result code |
| res_reply | output | 4 | Reply code from the first reply byte |
| res_dcount | output | CNT_W | Data byte count |

## Verification
The hardest case to reach from the ports is an error reply that arrives while reply bytes are already waiting on the receive stream. Only then can the rule that such replies consume nothing be seen. The stimulus loads the receive queue before raising `rep_start` with error flags, and afterwards counts the bytes still queued. The overflow and non-acknowledge paths also drain bytes without forwarding them. For those cases the bench expects an empty receive queue together with an empty data scoreboard. Random stalls on `tx_ready` and `dat_ready` keep bytes waiting mid-frame under back-pressure.

// File: rtl/aux_codec_pkg.sv
package aux_codec_pkg;
  localparam int ADDR_W = 20;
  localparam int CMD_W  = 4;

  // receiver flag positions
  localparam int FLG_TIMEOUT  = 0;
  localparam int FLG_BAD_STOP = 1;
  localparam int FLG_NO_DET   = 2;
  localparam int FLG_BAD_HI   = 3;
  localparam int FLG_BAD_LO   = 4;
  localparam int FLG_HPD_LOST = 5;
  localparam int FLG_W        = 6;

  localparam logic [3:0] REPLY_ACK = 4'h0;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_TIMEOUT  = 3'd1,
    RES_INVALID  = 3'd2,
    RES_HPD_LOST = 3'd3,
    RES_OVERFLOW = 3'd4
  } aux_res_e;
endpackage

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_codec_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [CNT_W-1:0]  tx_count
);
  typedef enum logic [1:0] {F_IDLE, F_HDR, F_PAY} fst_e;

  fst_e                 st_q;
  logic [3:0][7:0]      hdr_q;
  logic [1:0]           idx_q;
  logic [1:0]           hdr_end_q;
  logic [LEN_W-1:0]     pay_left_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 has_len;

  assign has_len   = (req_len != '0);
  assign req_ready = (st_q == F_IDLE);
  assign tx_count  = cnt_q;

  always_comb begin
    tx_valid  = 1'b0;
    tx_data   = hdr_q[idx_q];
    tx_last   = 1'b0;
    pay_ready = 1'b0;
    case (st_q)
      F_HDR: begin
        tx_valid = 1'b1;
        tx_last  = (idx_q == hdr_end_q) && (pay_left_q == '0);
      end
      F_PAY: begin
        tx_valid  = pay_valid;
        tx_data   = pay_data;
        pay_ready = tx_ready;
        tx_last   = (pay_left_q == LEN_W'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= F_IDLE;
      hdr_q      <= '0;
      idx_q      <= '0;
      hdr_end_q  <= '0;
      pay_left_q <= '0;
      cnt_q      <= '0;
    end else begin
      case (st_q)
        F_IDLE: if (req_valid) begin
          hdr_q[0]   <= {req_cmd, req_addr[19:16]};
          hdr_q[1]   <= req_addr[15:8];
          hdr_q[2]   <= req_addr[7:0];
          hdr_q[3]   <= 8'(req_len - LEN_W'(1));
          hdr_end_q  <= has_len ? 2'd3 : 2'd2;
          pay_left_q <= req_write ? req_len : '0;
          cnt_q      <= (has_len ? CNT_W'(4) : CNT_W'(3)) +
                        (req_write ? CNT_W'(req_len) : '0);
          idx_q      <= '0;
          st_q       <= F_HDR;
        end
        F_HDR: if (tx_ready) begin
          if (idx_q == hdr_end_q) begin
            st_q <= (pay_left_q != '0) ? F_PAY : F_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        F_PAY: if (pay_valid && tx_ready) begin
          pay_left_q <= pay_left_q - LEN_W'(1);
          if (pay_left_q == LEN_W'(1)) st_q <= F_IDLE;
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_rep_status.sv
module aux_rep_status
  import aux_codec_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [FLG_W-1:0] flags,
  input  logic [CNT_W-1:0] count,
  output logic             bad,
  output aux_res_e         code
);
  logic symbol_err;

  assign symbol_err = flags[FLG_BAD_STOP] | flags[FLG_NO_DET] |
                      flags[FLG_BAD_HI]   | flags[FLG_BAD_LO];

  always_comb begin
    bad  = 1'b1;
    code = RES_OK;
    if (flags[FLG_HPD_LOST])      code = RES_HPD_LOST;
    else if (flags[FLG_TIMEOUT])  code = RES_TIMEOUT;
    else if (symbol_err)          code = RES_INVALID;
    else if (count == '0)         code = RES_INVALID;
    else                          bad  = 1'b0;
  end
endmodule

// File: rtl/aux_rep_parser.sv
module aux_rep_parser
  import aux_codec_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rep_start,
  output logic             rep_ready,
  input  logic [CNT_W-1:0] rep_count,
  input  logic [CNT_W-1:0] rep_limit,
  input  logic             st_bad,
  input  aux_res_e         st_code,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  output logic             dat_valid,
  input  logic             dat_ready,
  output logic [7:0]       dat_data,
  output logic             res_valid,
  output aux_res_e         res_code,
  output logic [3:0]       res_reply,
  output logic [CNT_W-1:0] res_dcount
);
  typedef enum logic [1:0] {P_IDLE, P_HEAD, P_BODY, P_RES} pst_e;

  pst_e             st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] left_q;
  logic             fwd_q;
  logic             ovf_q;
  logic [CNT_W-1:0] rem;
  logic             is_ack;

  assign rem       = cnt_q - CNT_W'(1);
  assign is_ack    = (rx_data[7:4] == REPLY_ACK);
  assign rep_ready = (st_q == P_IDLE);
  assign res_valid = (st_q == P_RES);
  assign dat_data  = rx_data;
  assign dat_valid = (st_q == P_BODY) && fwd_q && rx_valid;

  always_comb begin
    case (st_q)
      P_HEAD:  rx_ready = 1'b1;
      P_BODY:  rx_ready = fwd_q ? dat_ready : 1'b1;
      default: rx_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= P_IDLE;
      cnt_q      <= '0;
      lim_q      <= '0;
      left_q     <= '0;
      fwd_q      <= 1'b0;
      ovf_q      <= 1'b0;
      res_code   <= RES_OK;
      res_reply  <= '0;
      res_dcount <= '0;
    end else begin
      case (st_q)
        P_IDLE: if (rep_start) begin
          cnt_q <= rep_count;
          lim_q <= rep_limit;
          if (st_bad) begin
            res_code   <= st_code;
            res_reply  <= '0;
            res_dcount <= '0;
            st_q       <= P_RES;
          end else begin
            st_q <= P_HEAD;
          end
        end
        P_HEAD: if (rx_valid) begin
          res_reply <= rx_data[7:4];
          if (rem == '0) begin
            res_code   <= RES_OK;
            res_dcount <= '0;
            st_q       <= P_RES;
          end else begin
            fwd_q  <= is_ack && (rem <= lim_q);
            ovf_q  <= is_ack && (rem > lim_q);
            left_q <= rem;
            st_q   <= P_BODY;
          end
        end
        P_BODY: if (rx_valid && rx_ready) begin
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            res_code   <= ovf_q ? RES_OVERFLOW : RES_OK;
            res_dcount <= ovf_q ? '0 : rem;
            st_q       <= P_RES;
          end
        end
        P_RES: st_q <= P_IDLE;
        default: st_q <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_xact_codec.sv
module aux_xact_codec
  import aux_codec_pkg::*;
#(
  parameter  int MAX_LEN = 16,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int CNT_W   = $clog2(MAX_LEN + 5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [19:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic [CNT_W-1:0]  tx_count,
  input  logic              rep_start,
  output logic              rep_ready,
  input  logic [CNT_W-1:0]  rep_count,
  input  logic [CNT_W-1:0]  rep_limit,
  input  logic [5:0]        rep_flags,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [7:0]        dat_data,
  output logic              res_valid,
  output logic [2:0]        res_code,
  output logic [3:0]        res_reply,
  output logic [CNT_W-1:0]  res_dcount
);
  logic     st_bad;
  aux_res_e st_code;
  aux_res_e res_code_e;

  assign res_code = res_code_e;

  aux_req_framer #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_count(tx_count)
  );

  aux_rep_status #(.CNT_W(CNT_W)) u_status (
    .flags(rep_flags), .count(rep_count), .bad(st_bad), .code(st_code)
  );

  aux_rep_parser #(.CNT_W(CNT_W)) u_parser (
    .clk(clk), .rst_n(rst_n),
    .rep_start(rep_start), .rep_ready(rep_ready),
    .rep_count(rep_count), .rep_limit(rep_limit),
    .st_bad(st_bad), .st_code(st_code),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
    .res_valid(res_valid), .res_code(res_code_e),
    .res_reply(res_reply), .res_dcount(res_dcount)
  );
endmodule

// File: rtl/aux_xact_codec_chk.sv
module aux_xact_codec_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             rep_start,
  input logic             rep_ready,
  input logic [5:0]       rep_flags,
  input logic             res_valid,
  input logic [2:0]       res_code,
  input logic [CNT_W-1:0] res_dcount,
  input logic             dat_valid
);
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_req_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_res_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_hpd_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_start && rep_ready && rep_flags[5] |=> res_valid && res_code == 3'd3);

  assert_timeout_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rep_start && rep_ready && !rep_flags[5] && rep_flags[0]
      |=> res_valid && res_code == 3'd1);

  assert_err_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_code != 3'd0 |-> res_dcount == '0);

  assert_data_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> !rep_ready);
endmodule

bind aux_xact_codec aux_xact_codec_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .rep_start(rep_start), .rep_ready(rep_ready), .rep_flags(rep_flags),
  .res_valid(res_valid), .res_code(res_code), .res_dcount(res_dcount),
  .dat_valid(dat_valid)
);

// File: tb/aux_xact_codec_bench.sv
`timescale 1ns/1ps
module aux_xact_codec_bench;
  localparam int MAX_LEN = 16;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 5);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             req_valid = 0, req_write = 0;
  logic [3:0]       req_cmd = 0;
  logic [19:0]      req_addr = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic             req_ready;
  logic             pay_valid, pay_ready;
  logic [7:0]       pay_data;
  logic             tx_valid, tx_ready, tx_last;
  logic [7:0]       tx_data;
  logic [CNT_W-1:0] tx_count;
  logic             rep_start = 0, rep_ready;
  logic [CNT_W-1:0] rep_count = 0, rep_limit = 0;
  logic [5:0]       rep_flags = 0;
  logic             rx_valid, rx_ready;
  logic [7:0]       rx_data;
  logic             dat_valid, dat_ready;
  logic [7:0]       dat_data;
  logic             res_valid;
  logic [2:0]       res_code;
  logic [3:0]       res_reply;
  logic [CNT_W-1:0] res_dcount;

  aux_xact_codec #(.MAX_LEN(MAX_LEN)) u_aux_xact_codec (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_count(tx_count),
    .rep_start(rep_start), .rep_ready(rep_ready), .rep_count(rep_count),
    .rep_limit(rep_limit), .rep_flags(rep_flags),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
    .res_valid(res_valid), .res_code(res_code), .res_reply(res_reply),
    .res_dcount(res_dcount)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit stall = 0;

  logic [7:0] pay_q[$];
  logic [7:0] rx_q[$];
  logic [7:0] exp_tx_d[$];
  bit         exp_tx_l[$];
  int         exp_tx_c[$];
  string      exp_tx_tag[$];
  logic [7:0] exp_dat[$];
  int         exp_code[$];
  int         exp_reply[$];
  int         exp_dcnt[$];
  string      exp_rtag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // ready drivers
  initial begin
    tx_ready = 1'b1;
    dat_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      tx_ready  = stall ? ($urandom % 3 != 0) : 1'b1;
      dat_ready = stall ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  // payload source
  initial begin
    bit hs;
    pay_valid = 1'b0;
    pay_data = '0;
    forever begin
      @(negedge clk);
      hs = pay_valid && pay_ready;
      @(posedge clk); #1;
      if (hs) void'(pay_q.pop_front());
      pay_valid = (pay_q.size() != 0);
      pay_data  = pay_valid ? pay_q[0] : 8'h00;
    end
  end

  // receive source
  initial begin
    bit hs;
    rx_valid = 1'b0;
    rx_data = '0;
    forever begin
      @(negedge clk);
      hs = rx_valid && rx_ready;
      @(posedge clk); #1;
      if (hs) void'(rx_q.pop_front());
      rx_valid = (rx_q.size() != 0);
      rx_data  = rx_valid ? rx_q[0] : 8'h00;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        if (exp_tx_d.size() == 0) begin
          check(1'b0, "R4", "unexpected tx byte", int'(tx_data), -1);
        end else begin
          automatic logic [7:0] d = exp_tx_d.pop_front();
          automatic bit l = exp_tx_l.pop_front();
          automatic int c = exp_tx_c.pop_front();
          automatic string t = exp_tx_tag.pop_front();
          check(tx_data == d, t, "tx byte", int'(tx_data), int'(d));
          check(tx_last == l, "R4", "tx_last", int'(tx_last), int'(l));
          check(int'(tx_count) == c, "R4", "tx_count", int'(tx_count), c);
          check(!req_ready, "R12", "req_ready during frame", int'(req_ready), 0);
        end
      end
      if (dat_valid && dat_ready) begin
        if (exp_dat.size() == 0) begin
          check(1'b0, "R10", "unexpected data byte", int'(dat_data), -1);
        end else begin
          automatic logic [7:0] d = exp_dat.pop_front();
          check(dat_data == d, "R10", "data byte", int'(dat_data), int'(d));
        end
      end
      if (res_valid) begin
        if (exp_code.size() == 0) begin
          check(1'b0, "R12", "unexpected result", int'(res_code), -1);
        end else begin
          automatic int c = exp_code.pop_front();
          automatic int r = exp_reply.pop_front();
          automatic int n = exp_dcnt.pop_front();
          automatic string t = exp_rtag.pop_front();
          check(int'(res_code) == c, t, "res_code", int'(res_code), c);
          check(int'(res_reply) == r, t, "res_reply", int'(res_reply), r);
          check(int'(res_dcount) == n, t, "res_dcount", int'(res_dcount), n);
        end
      end
    end
  end

  task automatic push_tx(input logic [7:0] d, input bit l, input int c, input string t);
    exp_tx_d.push_back(d);
    exp_tx_l.push_back(l);
    exp_tx_c.push_back(c);
    exp_tx_tag.push_back(t);
  endtask

  task automatic send_req(input logic [3:0] cmd, input logic [19:0] addr,
                          input int len, input bit wr);
    int hdr = (len != 0) ? 4 : 3;
    int tot = hdr + (wr ? len : 0);
    push_tx({cmd, addr[19:16]}, tot == 1, tot, "R1");
    push_tx(addr[15:8], 1'b0, tot, "R2");
    push_tx(addr[7:0], tot == 3, tot, "R2");
    if (len != 0) push_tx(8'(len - 1), tot == 4, tot, "R3");
    if (wr) begin
      for (int k = 0; k < len; k++) begin
        automatic logic [7:0] b = 8'($urandom);
        pay_q.push_back(b);
        push_tx(b, (hdr + k) == tot - 1, tot, "R4");
      end
    end
    @(posedge clk); #1;
    req_cmd = cmd; req_addr = addr; req_len = LEN_W'(len); req_write = wr;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (exp_tx_d.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // rx_q is filled by the caller before this task
  task automatic send_rep(input logic [5:0] flags, input int count, input int limit,
                          input int ecode, input int ereply, input int edcnt,
                          input bit fwd, input int left, input string tag);
    if (fwd) begin
      for (int k = 1; k < rx_q.size(); k++) exp_dat.push_back(rx_q[k]);
    end
    exp_code.push_back(ecode);
    exp_reply.push_back(ereply);
    exp_dcnt.push_back(edcnt);
    exp_rtag.push_back(tag);
    @(posedge clk); #1;
    rep_flags = flags; rep_count = CNT_W'(count); rep_limit = CNT_W'(limit);
    rep_start = 1'b1;
    do @(negedge clk); while (!rep_ready);
    @(posedge clk); #1;
    rep_start = 1'b0;
    while (exp_code.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_dat.size() == 0, tag, "data bytes outstanding", exp_dat.size(), 0);
    check(rx_q.size() == left, tag, "reply bytes left unread", rx_q.size(), left);
    rx_q.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R12 watchdog: actual hung expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R12", "reset req_ready", int'(req_ready), 1);
    check(tx_valid == 1'b0, "R4", "reset tx_valid", int'(tx_valid), 0);
    check(rep_ready == 1'b1, "R12", "reset rep_ready", int'(rep_ready), 1);
    check(res_valid == 1'b0, "R12", "reset res_valid", int'(res_valid), 0);
    check(dat_valid == 1'b0, "R10", "reset dat_valid", int'(dat_valid), 0);

    // framing
    send_req(4'h8, 20'h12345, 3, 1'b1);
    check(pay_q.size() == 0, "R4", "payload left after write", pay_q.size(), 0);
    stall = 1;
    send_req(4'h4, 20'h00050, 0, 1'b1);
    pay_q.push_back(8'hEE);
    send_req(4'h9, 20'hABCDE, 16, 1'b0);
    check(pay_q.size() == 1, "R4", "payload taken by read", pay_q.size(), 1);
    pay_q.delete();
    repeat (2) @(negedge clk);
    send_req(4'h0, 20'hF00F1, 1, 1'b1);
    send_req(4'hC, 20'h7A5C3, 16, 1'b1);

    // replies
    rx_q = '{8'h00, 8'h11, 8'h22, 8'h33};
    send_rep(6'h00, 4, 16, 0, 0, 3, 1'b1, 0, "R10");
    rx_q = '{8'h20};
    send_rep(6'h00, 1, 16, 0, 2, 0, 1'b0, 0, "R10");
    rx_q = '{8'h10, 8'h55, 8'h66};
    send_rep(6'h00, 3, 16, 0, 1, 2, 1'b0, 0, "R10");
    rx_q = '{8'h00, 8'h44};
    send_rep(6'h21, 2, 16, 3, 0, 0, 1'b0, 2, "R6");
    rx_q = '{8'h00, 8'h44};
    send_rep(6'h03, 2, 16, 1, 0, 0, 1'b0, 2, "R7");
    rx_q = '{8'h00, 8'h44};
    send_rep(6'h04, 2, 16, 2, 0, 0, 1'b0, 2, "R8");
    rx_q = '{8'h00};
    send_rep(6'h10, 1, 16, 2, 0, 0, 1'b0, 1, "R8");
    send_rep(6'h00, 0, 16, 2, 0, 0, 1'b0, 0, "R9");
    rx_q = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04};
    send_rep(6'h00, 5, 2, 4, 0, 0, 1'b0, 0, "R11");
    rx_q = '{8'h00, 8'h07, 8'h08};
    send_rep(6'h00, 3, 2, 0, 0, 2, 1'b1, 0, "R11");

    check(exp_tx_d.size() == 0, "R4", "tx bytes outstanding", exp_tx_d.size(), 0);
    report();
    $finish;
  end
endmodule